// File: doc/BRIEF.md
# Miss Tracking File with Warp Merging

This block records the L1 cache misses that are still waiting for memory in one streaming multiprocessor. Each entry holds the line address of one missing cache line and a short list of the warps that want that line. When a miss arrives, its line address is compared in the same cycle against every live entry. If the address matches an entry, the warp joins that entry and nothing goes downstream. If no entry matches, the lowest-numbered empty entry is claimed and a single memory request leaves the block. If no entry can take the miss, the requester sees a stall.

There are two distinct stall causes, and each has its own pulse. One is a matched entry whose warp list is already full. The other is the case where no entry matches and none is empty. Each outcome (merge, allocate, and the two stalls) pulses for one cycle so that counters outside the block can tally them.

When memory returns a line, the fill names the entry index. From the next cycle on, the block replays the warps recorded in that entry, one per cycle, in the order they arrived. It frees the entry at the end of the last replay cycle.

Top module: `mshr_merge_file`

## Requirements
- R1: After reset no entry is live: `wake_valid` is 0, `fill_ready` is 1, and the first miss to any address allocates entry 0.
- R2: A miss whose address matches no live entry takes the lowest-numbered empty entry. In the same cycle it raises `alloc_pulse` and `mem_req_valid`, with `mem_req_addr` equal to the miss address and `mem_req_idx` equal to that entry.
- R3: A miss whose address matches a live entry that has fewer than NUM_SLOTS warps raises `merge_pulse`. It is stored in the next free slot of that entry and sends no memory request.
- R4: A miss that matches an entry already holding NUM_SLOTS warps raises `req_stall` and `merger_full_stall`. It does not raise `entry_full_stall`, and the entry stays unchanged.
- R5: A miss that matches no entry while all NUM_ENTRIES entries are live raises `req_stall` and `entry_full_stall`. It does not raise `merger_full_stall`, and no memory request is sent.
- R6: A fill accepted for a live entry holding n warps makes `wake_valid` high for n cycles, starting in the cycle after acceptance. `wake_warp` gives the stored warp IDs in arrival order, and then the entry is empty.
- R7: An entry freed in its last replay cycle cannot be allocated in that same cycle. It can be allocated from the next cycle on.
- R8: An entry whose warps are being replayed takes no merges. A miss to its address in that window allocates a fresh entry.
- R9: `fill_ready` is low while a replay is in progress. A fill naming an empty entry produces no replay.
- R10: With `req_valid` high, exactly one of `merge_pulse`, `alloc_pulse`, `entry_full_stall` and `merger_full_stall` is high. With `req_valid` low, all four and `req_stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A miss is presented this cycle |
| req_addr | input | ADDR_W | Line address of the miss |
| req_warp | input | WARP_W | ID of the warp that missed |
| req_stall | output | 1 | Miss not accepted; present it again later |
| merge_pulse | output | 1 | Miss merged into a live entry |
| alloc_pulse | output | 1 | Miss claimed a new entry |
| entry_full_stall | output | 1 | Stall because every entry is live |
| merger_full_stall | output | 1 | Stall because the matched entry's warp list is full |
| mem_req_valid | output | 1 | Memory request for a newly claimed entry |
| mem_req_addr | output | ADDR_W | Line address of the memory request |
| mem_req_idx | output | $clog2(NUM_ENTRIES) | Entry index the fill must return |
| fill_valid | input | 1 | A line has returned from memory |
| fill_idx | input | $clog2(NUM_ENTRIES) | Entry the returned line belongs to |
| fill_ready | output | 1 | No replay in progress; a fill can be taken |
| wake_valid | output | 1 | A waiting warp is released this cycle |
| wake_warp | output | WARP_W | ID of the released warp |

## Verification
The bench runs a configuration with 4 entries and 3 slots. It fills entries to every depth from one to three warps and compares each outcome and each replay against a model of its own. A design that confused the two stall causes, or merged into a full entry, would pulse the wrong stall or overwrite a warp ID. A design that replayed slots in the wrong order or freed the entry early would put the wrong `wake_warp` sequence on the port.

One sequence issues a miss to the address of the entry being drained, in the same cycle the entry is freed. A design that merged into that entry would lose the warp. A design that reused the entry in that cycle would report index 0 instead of 1. The bench also sends a fill for an empty entry, and a design without the liveness check would replay stale warp IDs there.

// File: rtl/mshr_merge_file.sv
module mshr_merge_file #(
  parameter int NUM_ENTRIES = 32,
  parameter int NUM_SLOTS   = 8,
  parameter int ADDR_W      = 26,
  parameter int WARP_W      = 6,
  localparam int IDX_W  = $clog2(NUM_ENTRIES),
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WARP_W-1:0] req_warp,
  output logic              req_stall,
  output logic              merge_pulse,
  output logic              alloc_pulse,
  output logic              entry_full_stall,
  output logic              merger_full_stall,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [IDX_W-1:0]  mem_req_idx,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_idx,
  output logic              fill_ready,
  output logic              wake_valid,
  output logic [WARP_W-1:0] wake_warp
);

  logic [NUM_ENTRIES-1:0] live;
  logic [ADDR_W-1:0]      line_q [NUM_ENTRIES];
  logic [CNT_W-1:0]       cnt_q  [NUM_ENTRIES];
  logic [WARP_W-1:0]      warp_q [NUM_ENTRIES][NUM_SLOTS];

  logic              draining;
  logic [IDX_W-1:0]  drain_idx;
  logic [SLOT_W-1:0] rd_ptr;

  logic             hit, any_free, slots_full, last_slot, fill_take;
  logic [IDX_W-1:0] hit_idx, free_idx;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int e = 0; e < NUM_ENTRIES; e++)
      if (live[e] && !(draining && drain_idx == IDX_W'(e)) && line_q[e] == req_addr) begin
        hit = 1'b1;
        hit_idx = IDX_W'(e);
      end
    any_free = 1'b0;
    free_idx = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--)
      if (!live[e]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(e);
      end
  end

  assign slots_full        = cnt_q[hit_idx] == CNT_W'(NUM_SLOTS);
  assign merger_full_stall = req_valid & hit & slots_full;
  assign merge_pulse       = req_valid & hit & ~slots_full;
  assign alloc_pulse       = req_valid & ~hit & any_free;
  assign entry_full_stall  = req_valid & ~hit & ~any_free;
  assign req_stall         = merger_full_stall | entry_full_stall;

  assign mem_req_valid = alloc_pulse;
  assign mem_req_addr  = req_addr;
  assign mem_req_idx   = free_idx;

  assign fill_ready = ~draining;
  assign fill_take  = fill_valid & ~draining & live[fill_idx];
  assign wake_valid = draining;
  assign wake_warp  = warp_q[drain_idx][rd_ptr];
  assign last_slot  = CNT_W'(rd_ptr) == cnt_q[drain_idx] - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live      <= '0;
      draining  <= 1'b0;
      drain_idx <= '0;
      rd_ptr    <= '0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        line_q[e] <= '0;
        cnt_q[e]  <= '0;
        for (int s = 0; s < NUM_SLOTS; s++) warp_q[e][s] <= '0;
      end
    end else begin
      if (alloc_pulse) begin
        live[free_idx]      <= 1'b1;
        line_q[free_idx]    <= req_addr;
        cnt_q[free_idx]     <= CNT_W'(1);
        warp_q[free_idx][0] <= req_warp;
      end
      if (merge_pulse) begin
        warp_q[hit_idx][cnt_q[hit_idx][SLOT_W-1:0]] <= req_warp;
        cnt_q[hit_idx] <= cnt_q[hit_idx] + CNT_W'(1);
      end
      if (draining) begin
        if (last_slot) begin
          draining        <= 1'b0;
          live[drain_idx] <= 1'b0;
        end else begin
          rd_ptr <= rd_ptr + SLOT_W'(1);
        end
      end else if (fill_take) begin
        draining  <= 1'b1;
        drain_idx <= fill_idx;
        rd_ptr    <= '0;
      end
    end
  end

endmodule

// File: rtl/mshr_merge_file_chk.sv
module mshr_merge_file_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_stall,
  input logic merge_pulse,
  input logic alloc_pulse,
  input logic entry_full_stall,
  input logic merger_full_stall,
  input logic mem_req_valid,
  input logic fill_ready,
  input logic wake_valid
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({merge_pulse, alloc_pulse, entry_full_stall, merger_full_stall}) == 1); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(merge_pulse | alloc_pulse | entry_full_stall | merger_full_stall | req_stall)); // R10
  AST_MERGE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    merge_pulse |-> !mem_req_valid); // R3
  AST_STALL_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    req_stall |-> !mem_req_valid); // R5
  AST_MFULL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    merger_full_stall |-> req_stall && !entry_full_stall); // R4
  AST_BUSY_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> !fill_ready); // R9
endmodule

bind mshr_merge_file mshr_merge_file_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_stall(req_stall),
  .merge_pulse(merge_pulse), .alloc_pulse(alloc_pulse),
  .entry_full_stall(entry_full_stall), .merger_full_stall(merger_full_stall),
  .mem_req_valid(mem_req_valid), .fill_ready(fill_ready), .wake_valid(wake_valid)
);

// File: tb/mshr_merge_file_tb_top.sv
module mshr_merge_file_tb_top;
  localparam int E = 4, S = 3, AW = 8, WW = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, fill_valid = 0;
  logic [AW-1:0] req_addr = 0;
  logic [WW-1:0] req_warp = 0;
  logic [1:0] fill_idx = 0;
  logic req_stall, merge_pulse, alloc_pulse, entry_full_stall, merger_full_stall;
  logic mem_req_valid, fill_ready, wake_valid;
  logic [AW-1:0] mem_req_addr;
  logic [1:0] mem_req_idx;
  logic [WW-1:0] wake_warp;

  int checks = 0, errors = 0;
  bit done = 0;

  bit      m_live [E];
  int      m_addr [E];
  int      m_cnt  [E];
  int      m_w    [E][S];

  always #10 clk = ~clk;

  mshr_merge_file #(.NUM_ENTRIES(E), .NUM_SLOTS(S), .ADDR_W(AW), .WARP_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_warp(req_warp),
    .req_stall(req_stall), .merge_pulse(merge_pulse), .alloc_pulse(alloc_pulse),
    .entry_full_stall(entry_full_stall), .merger_full_stall(merger_full_stall),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_idx(mem_req_idx),
    .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_ready(fill_ready),
    .wake_valid(wake_valid), .wake_warp(wake_warp));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_req(input int addr, input int warp);
    int hit = -1, fr = -1;
    for (int e = 0; e < E; e++) if (m_live[e] && m_addr[e] == addr) hit = e;
    for (int e = E - 1; e >= 0; e--) if (!m_live[e]) fr = e;
    @(negedge clk);
    req_valid = 1; req_addr = AW'(addr); req_warp = WW'(warp);
    #1;
    if (hit >= 0 && m_cnt[hit] == S) begin
      chk(merger_full_stall && req_stall, "R4 merger stall", merger_full_stall, 1);
      chk(!entry_full_stall && !mem_req_valid, "R4 no entry stall", entry_full_stall, 0);
    end else if (hit >= 0) begin
      chk(merge_pulse && !req_stall, "R3 merge", merge_pulse, 1);
      chk(!mem_req_valid && !alloc_pulse, "R3 no mem req", mem_req_valid, 0);
      m_w[hit][m_cnt[hit]] = warp; m_cnt[hit]++;
    end else if (fr < 0) begin
      chk(entry_full_stall && req_stall, "R5 entry stall", entry_full_stall, 1);
      chk(!merger_full_stall && !mem_req_valid, "R5 no merger stall", merger_full_stall, 0);
    end else begin
      chk(alloc_pulse && mem_req_valid && !req_stall, "R2 alloc", alloc_pulse, 1);
      chk(mem_req_idx == 2'(fr), "R2 lowest free idx", mem_req_idx, fr);
      chk(mem_req_addr == AW'(addr), "R2 mem addr", mem_req_addr, addr);
      m_live[fr] = 1; m_addr[fr] = addr; m_cnt[fr] = 1; m_w[fr][0] = warp;
    end
    chk((merge_pulse + alloc_pulse + entry_full_stall + merger_full_stall) == 1, "R10 one outcome",
        merge_pulse + alloc_pulse + entry_full_stall + merger_full_stall, 1);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic do_fill(input int idx);
    @(negedge clk);
    fill_valid = 1; fill_idx = 2'(idx);
    @(negedge clk);
    fill_valid = 0;
    for (int s = 0; s < m_cnt[idx]; s++) begin
      if (s > 0) @(negedge clk);
      #1;
      chk(wake_valid && !fill_ready, "R6 wake valid", wake_valid, 1);
      chk(wake_warp == WW'(m_w[idx][s]), "R6 wake order", wake_warp, m_w[idx][s]);
    end
    @(negedge clk); #1;
    chk(!wake_valid && fill_ready, "R6 replay ends", wake_valid, 0);
    m_live[idx] = 0;
  endtask

  task automatic fill_empty(input int idx);
    @(negedge clk);
    fill_valid = 1; fill_idx = 2'(idx);
    @(negedge clk);
    fill_valid = 0;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(!wake_valid && fill_ready, "R9 empty fill ignored", wake_valid, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    for (int e = 0; e < E; e++) m_live[e] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    chk(!wake_valid && fill_ready && !req_stall, "R1 reset state", wake_valid, 0);

    for (int r = 0; r < 2; r++) begin
      int k[E];
      for (int e = 0; e < E; e++) k[e] = ((e + r) % S) + 1;
      for (int s = 0; s < S; s++)
        for (int e = 0; e < E; e++)
          if (s < k[e]) do_req(r * 64 + e * 5 + 1, (e * S + s + r) % 16);
      do_req(200 + r, 9);
      for (int e = 0; e < E; e++) if (k[e] == S) do_req(r * 64 + e * 5 + 1, 15);
      for (int i = 0; i < E; i++) do_fill((i * 3 + r) % E);
      fill_empty(r);
    end

    do_req(77, 5);
    @(negedge clk);
    fill_valid = 1; fill_idx = 0;
    @(negedge clk);
    fill_valid = 0;
    req_valid = 1; req_addr = 77; req_warp = 6;
    #1;
    chk(wake_valid && wake_warp == 5, "R6 single replay", wake_warp, 5);
    chk(!fill_ready, "R9 busy during replay", fill_ready, 0);
    chk(alloc_pulse && !merge_pulse, "R8 no merge into draining entry", merge_pulse, 0);
    chk(mem_req_idx == 1, "R7 freed entry not reused same cycle", mem_req_idx, 1);
    @(posedge clk); #1;
    req_valid = 0;
    m_live[0] = 0;
    m_live[1] = 1; m_addr[1] = 77; m_cnt[1] = 1; m_w[1][0] = 6;
    do_req(90, 7);
    chk(m_live[0] && m_addr[0] == 90, "R7 reuse next cycle", m_addr[0], 90);
    do_fill(1);
    do_fill(0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule